// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation that has missed in the on-chip TLB by searching a hashed page table held in memory. The TLB sequencer hands it a virtual segment ID and a page index. The walker computes the primary group index and reads that group's eight entries one at a time. It compares each valid entry against the full virtual page number. If no entry in the primary group matches, it computes the secondary index and searches that group the same way. It then returns one response: either the real page number of the first matching entry, or a miss that the requester turns into a page fault.

The table is global, so no process ID takes part in the compare. Software sets its location and size through one configuration word, which the walker samples when it accepts a request. Both the request and the response channels use valid/ready. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole walk. Once `rsp_valid` rises, it and the response fields stay unchanged until the cycle where `rsp_ready` is high. The memory side is a read port with at most one read outstanding. An address is offered with valid/ready. The matching data returns later on a single-cycle `mem_rsp_valid` pulse, which the walker always accepts.

Top module: `hpt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. A request is accepted only while the walker is idle, and `req_ready` is 0 from the cycle after acceptance until the response has been taken.
- R2: The configuration word is read as follows. Bits [4:0] give the size code n; the table has 2^n groups, and a code above HASH_W counts as HASH_W. The table base is the word with bits [6:0] forced to zero, so bits [6:5] have no effect. Each group occupies 128 bytes starting at base + group*128.
- R3: The primary group index is (vsid[HASH_W-1:0] XOR vpi[HASH_W-1:0]) AND mask, where mask = 2^n - 1. The secondary index is (NOT (vsid XOR vpi)) AND the same mask.
- R4: Each memory read fetches one 16-byte entry at group address + slot*16. Slots are read in the order 0 to 7. No new read is issued until the data of the previous read has returned.
- R5: An entry is 128 bits: bit 0 is valid, bit 1 is the hash-select flag, bits [8 +: VSID_W+VPI_W] hold the tag {vsid, vpi} with vsid in the upper part, and bits [64 +: RPN_W] hold the real page number. An entry matches only if it is valid, its tag equals the request, and its flag is 0 during the primary search or 1 during the secondary search.
- R6: The search stops at the first matching entry in read order. The response then reports `rsp_hit`=1 and that entry's real page number, and no further reads are issued.
- R7: The secondary group is read only after all 8 primary entries have failed to match. `rsp_second` is 1 exactly when the hit came from the secondary group.
- R8: If neither group matches, the walker makes exactly 16 reads and responds with `rsp_hit`=0, `rsp_second`=0 and `rsp_rpn`=0.
- R9: Each accepted request produces exactly one response. While `rsp_ready` is low, `rsp_valid` and all response fields hold their values.
- R10: While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold their values.
- R11: The configuration word is sampled when a request is accepted. Changing it during a walk does not affect that walk's addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_table | input | PA_W | Table base (bits above 6) and size code (bits 4:0) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vsid | input | VSID_W | Virtual segment ID of the request |
| req_vpi | input | VPI_W | Page index within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_second | output | 1 | Hit came from the secondary group |
| rsp_rpn | output | RPN_W | Real page number of the hit, 0 on miss |
| mem_req_valid | output | 1 | Entry read address present |
| mem_req_ready | input | 1 | Memory takes the address |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 128 | Entry contents |

## Verification
The bench sweeps the position of the matching entry through all 16 slots, plus a miss, for table sizes of 1, 2, 4 and 8 groups. For each request it checks both the result and the exact order of the addresses read. It places decoys just before the real entry: an invalid entry with the right tag, an entry whose hash-select flag is wrong, and an entry whose tag differs in one bit. A design that ignored the flag or the valid bit would stop early with the wrong page number. A design that did not stop at the first hit would over-read, and one that probed the secondary group first would show a wrong address order. The one-group table makes both probes land in the same group, where only the flag separates them. Some walks change the configuration word mid-flight or stall the response, which would expose a walker that used live configuration or dropped its response fields.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int ENTRY_W    = 128;
  localparam int SLOTS      = 8;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int ENT_SHIFT  = 4;                    // 16-byte entries
  localparam int GRP_SHIFT  = ENT_SHIFT + SLOT_W;   // 128-byte groups
  localparam int SIZE_W     = 5;
  localparam int VLD_BIT    = 0;
  localparam int HSEL_BIT   = 1;
  localparam int TAG_LSB    = 8;
  localparam int RPN_LSB    = 64;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2,
    WK_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VSID_W = 24,
  parameter int VPI_W  = 16,
  parameter int HASH_W = 11
) (
  input  logic [VSID_W-1:0]          vsid,
  input  logic [VPI_W-1:0]           vpi,
  input  logic [hpt_pkg::SIZE_W-1:0] size_code,
  output logic [HASH_W-1:0]          grp_pri,
  output logic [HASH_W-1:0]          grp_sec
);
  localparam int NW = hpt_pkg::SIZE_W + 1;

  logic [HASH_W-1:0] vsid_x, vpi_x, mix, mask;
  logic [NW-1:0]     eff_n;

  generate
    if (VPI_W >= HASH_W) begin : g_vpi_cut
      assign vpi_x = vpi[HASH_W-1:0];
    end else begin : g_vpi_pad
      assign vpi_x = {{(HASH_W-VPI_W){1'b0}}, vpi};
    end
    if (VSID_W >= HASH_W) begin : g_vsid_cut
      assign vsid_x = vsid[HASH_W-1:0];
    end else begin : g_vsid_pad
      assign vsid_x = {{(HASH_W-VSID_W){1'b0}}, vsid};
    end
  endgenerate

  always_comb begin
    if ({1'b0, size_code} > NW'(HASH_W)) eff_n = NW'(HASH_W);
    else                                 eff_n = {1'b0, size_code};
  end

  generate
    for (genvar i = 0; i < HASH_W; i++) begin : g_mask
      assign mask[i] = (NW'(i) < eff_n);
    end
  endgenerate

  assign mix     = vsid_x ^ vpi_x;
  assign grp_pri = mix & mask;
  assign grp_sec = ~mix & mask;
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int TAG_W = 40,
  parameter int RPN_W = 28
) (
  input  logic [hpt_pkg::ENTRY_W-1:0] entry,
  input  logic [TAG_W-1:0]            tag,
  input  logic                        second,
  output logic                        hit,
  output logic [RPN_W-1:0]            rpn
);
  import hpt_pkg::*;

  logic vld, sel_ok, tag_ok;

  assign vld    = entry[VLD_BIT];
  assign sel_ok = (entry[HSEL_BIT] == second);
  assign tag_ok = (entry[TAG_LSB +: TAG_W] == tag);
  assign hit    = vld && sel_ok && tag_ok;
  assign rpn    = entry[RPN_LSB +: RPN_W];
endmodule

// File: rtl/hpt_walk_ctl.sv
module hpt_walk_ctl #(
  parameter int PA_W   = 40,
  parameter int VSID_W = 24,
  parameter int VPI_W  = 16,
  parameter int RPN_W  = 28,
  parameter int HASH_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PA_W-1:0]             cfg_table,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [VSID_W-1:0]           req_vsid,
  input  logic [VPI_W-1:0]            req_vpi,
  output logic [VSID_W-1:0]           cur_vsid,
  output logic [VPI_W-1:0]            cur_vpi,
  output logic [hpt_pkg::SIZE_W-1:0]  cur_size,
  output logic                        cur_second,
  input  logic [HASH_W-1:0]           grp_pri,
  input  logic [HASH_W-1:0]           grp_sec,
  input  logic                        ent_hit,
  input  logic [RPN_W-1:0]            ent_rpn,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [PA_W-1:0]             mem_req_addr,
  input  logic                        mem_rsp_valid,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_hit,
  output logic                        rsp_second,
  output logic [RPN_W-1:0]            rsp_rpn
);
  import hpt_pkg::*;

  localparam int OFF_W = HASH_W + GRP_SHIFT;

  walk_state_e         state_q;
  logic [PA_W-1:0]     base_q;
  logic [SIZE_W-1:0]   size_q;
  logic [VSID_W-1:0]   vsid_q;
  logic [VPI_W-1:0]    vpi_q;
  logic                second_q;
  logic [SLOT_W-1:0]   slot_q;
  logic                hit_q, sec_hit_q;
  logic [RPN_W-1:0]    rpn_q;
  logic [HASH_W-1:0]   grp_cur;
  logic [OFF_W-1:0]    offset;
  logic                accept, last_slot;

  assign accept    = req_valid && (state_q == WK_IDLE);
  assign last_slot = (slot_q == SLOT_W'(SLOTS-1));

  always_comb begin
    grp_cur = second_q ? grp_sec : grp_pri;
    offset  = {grp_cur, slot_q, {ENT_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WK_IDLE;
      base_q    <= '0;
      size_q    <= '0;
      vsid_q    <= '0;
      vpi_q     <= '0;
      second_q  <= 1'b0;
      slot_q    <= '0;
      hit_q     <= 1'b0;
      sec_hit_q <= 1'b0;
      rpn_q     <= '0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (accept) begin
            base_q   <= {cfg_table[PA_W-1:GRP_SHIFT], {GRP_SHIFT{1'b0}}};
            size_q   <= cfg_table[SIZE_W-1:0];
            vsid_q   <= req_vsid;
            vpi_q    <= req_vpi;
            second_q <= 1'b0;
            slot_q   <= '0;
            state_q  <= WK_ISSUE;
          end
        end
        WK_ISSUE: begin
          if (mem_req_ready) state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_hit) begin
              hit_q     <= 1'b1;
              sec_hit_q <= second_q;
              rpn_q     <= ent_rpn;
              state_q   <= WK_RESP;
            end else if (!last_slot) begin
              slot_q  <= slot_q + 1'b1;
              state_q <= WK_ISSUE;
            end else if (!second_q) begin
              second_q <= 1'b1;
              slot_q   <= '0;
              state_q  <= WK_ISSUE;
            end else begin
              hit_q     <= 1'b0;
              sec_hit_q <= 1'b0;
              rpn_q     <= '0;
              state_q   <= WK_RESP;
            end
          end
        end
        WK_RESP: begin
          if (rsp_ready) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WK_IDLE);
  assign mem_req_valid = (state_q == WK_ISSUE);
  assign mem_req_addr  = base_q + PA_W'(offset);
  assign rsp_valid     = (state_q == WK_RESP);
  assign rsp_hit       = hit_q;
  assign rsp_second    = sec_hit_q;
  assign rsp_rpn       = rpn_q;
  assign cur_vsid      = vsid_q;
  assign cur_vpi       = vpi_q;
  assign cur_size      = size_q;
  assign cur_second    = second_q;

  // Checker-side read counter for the walk in progress
  logic [4:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                             rd_cnt <= '0;
    else if (req_valid && req_ready)        rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
  end

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready)
    else $error("request accepted while a walk continues");

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid)
    else $error("second read issued before data returned");

  p_second_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_second) |-> (rd_cnt > 5'd8))
    else $error("secondary hit before primary group exhausted");

  p_miss_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rd_cnt == 5'd16 && rsp_rpn == '0 && !rsp_second))
    else $error("miss response malformed");

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_second) && $stable(rsp_rpn)))
    else $error("response changed under back-pressure");

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("read address changed before acceptance");
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int PA_W   = 40,
  parameter int VSID_W = 24,
  parameter int VPI_W  = 16,
  parameter int RPN_W  = 28,
  parameter int HASH_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   cfg_table,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [VPI_W-1:0]  req_vpi,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_second,
  output logic [RPN_W-1:0]  rsp_rpn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [127:0]      mem_rsp_data
);
  import hpt_pkg::*;

  localparam int TAG_W = VSID_W + VPI_W;

  logic [VSID_W-1:0] cur_vsid;
  logic [VPI_W-1:0]  cur_vpi;
  logic [SIZE_W-1:0] cur_size;
  logic              cur_second;
  logic [HASH_W-1:0] grp_pri, grp_sec;
  logic              ent_hit;
  logic [RPN_W-1:0]  ent_rpn;

  hpt_hash #(.VSID_W(VSID_W), .VPI_W(VPI_W), .HASH_W(HASH_W)) u_hash (
    .vsid      (cur_vsid),
    .vpi       (cur_vpi),
    .size_code (cur_size),
    .grp_pri   (grp_pri),
    .grp_sec   (grp_sec)
  );

  hpt_match #(.TAG_W(TAG_W), .RPN_W(RPN_W)) u_match (
    .entry  (mem_rsp_data),
    .tag    ({cur_vsid, cur_vpi}),
    .second (cur_second),
    .hit    (ent_hit),
    .rpn    (ent_rpn)
  );

  hpt_walk_ctl #(
    .PA_W(PA_W), .VSID_W(VSID_W), .VPI_W(VPI_W), .RPN_W(RPN_W), .HASH_W(HASH_W)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_table     (cfg_table),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vsid      (req_vsid),
    .req_vpi       (req_vpi),
    .cur_vsid      (cur_vsid),
    .cur_vpi       (cur_vpi),
    .cur_size      (cur_size),
    .cur_second    (cur_second),
    .grp_pri       (grp_pri),
    .grp_sec       (grp_sec),
    .ent_hit       (ent_hit),
    .ent_rpn       (ent_rpn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_hit       (rsp_hit),
    .rsp_second    (rsp_second),
    .rsp_rpn       (rsp_rpn)
  );
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
  localparam logic [39:0] TBL_BASE = 40'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [39:0]   cfg_table = TBL_BASE;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [23:0]   req_vsid = '0;
  logic [15:0]   req_vpi = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_hit, rsp_second;
  logic [27:0]   rsp_rpn;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [39:0]   mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [127:0]  mem_rsp_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  hpt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_table(cfg_table),
    .req_valid(req_valid), .req_ready(req_ready), .req_vsid(req_vsid), .req_vpi(req_vpi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_second(rsp_second), .rsp_rpn(rsp_rpn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [127:0] tmem [0:63];
  logic [39:0]  addr_log [0:31];
  logic [39:0]  exp_addr [0:31];
  int           rd_n = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_ent(bit v, bit h, logic [39:0] tag, logic [27:0] rpn);
    logic [127:0] e;
    e = '0;
    e[0] = v;
    e[1] = h;
    e[8 +: 40] = tag;
    e[64 +: 28] = rpn;
    return e;
  endfunction

  function automatic logic [127:0] mem_rd(logic [39:0] a);
    longint d;
    d = longint'(a) - longint'(TBL_BASE);
    if (d >= 0 && (d >> 4) < 64) return tmem[int'(d >> 4)];
    return '0;
  endfunction

  // Reference search computed from the requirements (R2, R3, R5-R8)
  task automatic model(input logic [39:0] cfg, input logic [23:0] vs, input logic [15:0] vp,
                       output bit hit, output logic [27:0] rpn, output bit sec, output int nrd);
    longint base, msk, h, g2;
    int n;
    bit done;
    logic [127:0] e;
    base = longint'({cfg[39:7], 7'b0});
    n = int'(cfg[4:0]);
    if (n > 11) n = 11;
    msk = (longint'(1) << n) - 1;
    h = longint'(vs[10:0] ^ vp[10:0]) & msk;
    hit = 0; rpn = '0; sec = 0; nrd = 0; done = 0;
    for (int g = 0; g < 2; g++) begin
      g2 = (g == 0) ? h : ((~h) & msk);
      for (int s = 0; s < 8; s++) begin
        if (!done) begin
          exp_addr[nrd] = 40'(base + g2 * 128 + s * 16);
          e = mem_rd(exp_addr[nrd]);
          nrd++;
          if (e[0] && (e[1] == g[0]) && (e[8 +: 40] == {vs, vp})) begin
            hit = 1; rpn = e[64 +: 28]; sec = g[0]; done = 1;
          end
        end
      end
    end
  endtask

  // Memory agent: one read outstanding, variable accept stall and latency
  initial begin : mem_agent
    logic [39:0] cap;
    int lat, wt;
    bit acc;
    cap = '0; lat = 0; wt = 0; acc = 0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (acc) begin
        acc = 0;
        mem_req_ready = 1'b0;
        lat = 1 + (rd_n % 3);
      end else if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_rd(cap);
        end
      end else if (mem_req_valid) begin
        if (wt > 0) wt--;
        else begin
          cap = mem_req_addr;
          if (rd_n < 32) addr_log[rd_n] = cap;
          rd_n++;
          mem_req_ready = 1'b1;
          acc = 1;
          wt = rd_n % 2;
        end
      end
    end
  end

  task automatic do_req(input logic [39:0] cfg, input logic [23:0] vs, input logic [15:0] vp,
                        input bit bp, input bit cfg_swap);
    bit e_hit, e_sec, ok, h0, s0;
    logic [27:0] e_rpn, r0;
    int e_n, bad;
    model(cfg, vs, vp, e_hit, e_rpn, e_sec, e_n);
    cfg_table = cfg;
    @(negedge clk);
    rd_n = 0;
    req_vsid = vs; req_vpi = vp; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "req_ready during walk", longint'(req_ready), 0);
    if (cfg_swap) cfg_table = cfg ^ 40'h3;   // R11: live change must be ignored
    while (!rsp_valid) @(negedge clk);
    if (bp) begin
      h0 = rsp_hit; s0 = rsp_second; r0 = rsp_rpn;
      ok = 1;
      repeat (3) begin
        @(negedge clk);
        if (!rsp_valid || rsp_hit != h0 || rsp_second != s0 || rsp_rpn != r0) ok = 0;
      end
      chk(ok, "R9", "response held under back-pressure", longint'(rsp_rpn), longint'(r0));
    end
    chk(rsp_hit == e_hit, cfg_swap ? "R11/R6/R8" : "R6/R8", "hit", longint'(rsp_hit), longint'(e_hit));
    chk(rsp_rpn == e_rpn, "R5", "rpn", longint'(rsp_rpn), longint'(e_rpn));
    chk(rsp_second == e_sec, "R7", "second flag", longint'(rsp_second), longint'(e_sec));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R9", "single response", longint'(rsp_valid), 0);
    chk(rd_n == e_n, "R4/R6/R7", "read count", longint'(rd_n), longint'(e_n));
    bad = -1;
    for (int i = 0; i < e_n && i < rd_n && i < 32; i++)
      if (bad < 0 && addr_log[i] !== exp_addr[i]) bad = i;
    chk(bad < 0, cfg_swap ? "R11/R3" : "R2/R3/R4", "read address order",
        (bad < 0) ? 0 : longint'(addr_log[bad]), (bad < 0) ? 0 : longint'(exp_addr[bad]));
    cfg_table = cfg;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err);
    $finish;
  end

  initial begin : main
    int iter;
    logic [23:0] vs;
    logic [15:0] vp;
    logic [39:0] tag, cfg;
    longint pri, sec, msk;
    int g, s, grp;
    iter = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", longint'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", longint'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", longint'(mem_req_valid), 0);

    for (int n = 0; n < 4; n++) begin
      for (int pos = 0; pos <= 16; pos++) begin
        iter++;
        vs  = 24'h35A000 + 24'(iter * 7919);
        vp  = 16'(iter * 40503);
        tag = {vs, vp};
        cfg = TBL_BASE | 40'(n) | (40'(iter % 4) << 5);   // R2: bits 6:5 vary
        msk = (longint'(1) << n) - 1;
        pri = longint'(vs[10:0] ^ vp[10:0]) & msk;
        sec = (~pri) & msk;
        for (int i = 0; i < 64; i++)
          tmem[i] = mk_ent(1'b1, i[0], tag ^ 40'h100, 28'(i));
        for (int i = 0; i < 8; i++)
          tmem[int'(pri) * 8 + i] = mk_ent(1'b0, 1'b0, tag, 28'hBAD0 + 28'(i));
        tmem[int'(pri) * 8 + 3] = mk_ent(1'b1, 1'b1, tag, 28'hF1A9);   // secondary-flag entry in primary group
        if (pos < 16) begin
          g = pos / 8; s = pos % 8;
          grp = (g == 0) ? int'(pri) : int'(sec);
          if (s > 0) begin
            case (pos % 3)
              0: tmem[grp * 8 + s - 1] = mk_ent(1'b0, g[0], tag, 28'hD001);
              1: tmem[grp * 8 + s - 1] = mk_ent(1'b1, ~g[0], tag, 28'hD002);
              default: tmem[grp * 8 + s - 1] = mk_ent(1'b1, g[0], tag ^ (40'h1 << (pos % 40)), 28'hD003);
            endcase
          end
          if (s < 7) tmem[grp * 8 + 7] = mk_ent(1'b1, g[0], tag, 28'hC0DE);  // later duplicate
          tmem[grp * 8 + s] = mk_ent(1'b1, g[0], tag, 28'h1000 + 28'(pos * 16 + n));
        end
        do_req(cfg, vs, vp, (iter % 4) == 1, (iter % 3) == 2);
      end
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule